// File: doc/BRIEF.md
# Paged Configuration Sequencer with Refresh

This block is an SPI master that loads a configuration image into a target device. It runs the whole sequence by itself. It puts the target into configuration mode, erases it, writes the image in 16-byte pages and finalises programming. It then leaves configuration mode and repeats refresh plus status reads until the target reports a healthy configuration. The image arrives as a byte stream that the block pulls one byte at a time with a single strobe.

Each page goes out in its own chip-select frame: a four-byte increment-and-program header, then exactly sixteen image bytes, then a busy poll. A busy poll is a four-byte query followed by one byte read back; a non-zero byte means the target is still busy. Status reads return a 32-bit big-endian word. Any failure after the first command triggers cleanup before `error` is raised: an erase with its poll and status read, then a refresh and the settling wait. If the failure was a page that never stops being busy, the block also reports which page it was.

Top module: `cfg_page_seq`

## Requirements
- R1: After reset, `csN` is 1, `sclk` is 0, and `busy`, `done`, `error` and `errInPage` are all 0.
- R2: SPI mode 0, MSB first. `sclk` half period is HALF_DIV clock cycles, and the target samples `mosi` on `sclk` rising edges. Every command is one frame with `csN` low: header byte 0 is the opcode, byte 1 the operand, byte 2 is 00, and byte 3 is 01 for the page command and 00 otherwise. `csN` goes high between frames.
- R3: A `start` whose `imageLen` has a non-zero low nibble sets `error` on the next clock. No frame is sent and `busy` stays 0.
- R4: A run opens with enable (C6, operand 08), a busy poll and a status read. It then sends erase (0E, operand 04), a busy poll and a status read. Status bit 13 set after either step is a failure.
- R5: A busy poll is F0 00 00 00 followed by one byte read. A non-zero byte repeats the poll. The POLL_LIMIT-th consecutive non-zero reply is a failure.
- R6: Init-address (46, operand 00) is sent once, after the erase checks and before the first page.
- R7: Each page is 70 00 00 01 followed by 16 stream bytes in order, all in one frame, then a busy poll. `byteTake` is high for one cycle each time the byte on `dataIn` is taken. `imageLen/16` pages are written, and zero pages are allowed.
- R8: After the last page, program-done (5E) is sent, followed by a busy poll and a status read. Status bit 8 (DONE) clear is a failure.
- R9: Disable (26) is sent next. Then refresh (79), a wait of at least `refreshWait` cycles and a status read repeat until DONE (bit 8) is set, BUSY (bit 12) is clear and bits 23 to 25 are all 0. The REFRESH_LIMIT-th unhealthy reply is a failure.
- R10: On any failure after enable, the block sends erase 0E/04, a busy poll (its timeout is not a new failure), a status read, a refresh and the wait, and only then sets `error`.
- R11: A failure from a page's busy poll sets `errInPage` and puts that page's index (first page 0) on `errPage`. All other failures leave `errInPage` at 0.
- R12: `busy` is 1 from the clock after an accepted `start` until the run ends. `done` and `error` are never both 1, they hold until the next `start`, and a `start` while `busy` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (sampled only when idle) |
| imageLen | input | LEN_W | Image length in bytes |
| refreshWait | input | WAIT_W | Cycles to wait after each refresh |
| dataIn | input | 8 | Current image byte |
| byteTake | output | 1 | Byte on dataIn consumed this cycle |
| sclk | output | 1 | SPI clock |
| mosi | output | 1 | SPI data to target |
| csN | output | 1 | SPI chip select, active low |
| miso | input | 1 | SPI data from target |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run succeeded |
| error | output | 1 | Last run failed |
| errInPage | output | 1 | Failure was a page busy timeout |
| errPage | output | LEN_W-4 | Index of failing page |

## Verification
Two events can land in the same cycle. A second `start` can arrive while a frame is on the wire; the bench pulses `start` with a malformed length during a page run and checks that the run still ends in `done` with an unchanged command log. The final page's busy poll clearing can also fall in the same decision as the page counter reaching its end; runs of zero, one, two and three pages check that exactly one program-done follows the last page. A behavioural target model decodes every frame, answers polls and status reads from per-scenario settings, and compares the logged command sequence with one built from the requirements.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;
  localparam logic [7:0] OP_ENABLE  = 8'hC6;
  localparam logic [7:0] OP_ERASE   = 8'h0E;
  localparam logic [7:0] OP_INITA   = 8'h46;
  localparam logic [7:0] OP_PAGE    = 8'h70;
  localparam logic [7:0] OP_PDONE   = 8'h5E;
  localparam logic [7:0] OP_DISABLE = 8'h26;
  localparam logic [7:0] OP_REFRESH = 8'h79;
  localparam logic [7:0] OP_POLL    = 8'hF0;
  localparam logic [7:0] OP_STATUS  = 8'h3C;
  localparam logic [7:0] ARG_ENABLE = 8'h08;
  localparam logic [7:0] ARG_ERASE  = 8'h04;
  localparam int PAGE_BYTES = 16;
  localparam int HDR_BYTES  = 4;

  typedef struct packed {
    logic        go;
    logic [31:0] header;
    logic [4:0]  txBytes;
    logic [2:0]  rxBytes;
  } frameReq_t;

  typedef struct packed {
    logic [7:0] pollByte;
    logic       doneF;
    logic       busyF;
    logic       failF;
    logic [2:0] errF;
  } rsp_t;

  typedef enum logic [3:0] {
    S_IDLE, S_ENABLE, S_ERASE, S_POLL, S_STAT, S_INITA, S_PAGE, S_PDONE,
    S_DISABLE, S_REFRESH, S_WAIT, S_CL_ERASE, S_CL_REFRESH
  } seqState_t;

  typedef enum logic [2:0] {K_EN, K_ER, K_PG, K_PD, K_RF, K_CL} seqStep_t;
endpackage

// File: rtl/cfg_seq_spi.sv
module cfg_seq_spi
  import cfg_seq_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  frameReq_t req,
  output logic      frameBusy,
  output logic      frameDone,
  output rsp_t      rsp,
  input  logic [7:0] dataIn,
  output logic      byteTake,
  output logic      sclk,
  output logic      mosi,
  output logic      csN,
  input  logic      miso
);
  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic             active;
  logic [DIV_W-1:0] divCnt;
  logic [7:0]       bitCnt;
  logic [7:0]       txSh;
  logic [31:0]      hdr;
  logic [4:0]       txBytesR;
  logic [2:0]       rxBytesR;
  logic [25:0]      rxSh;
  logic [4:0]       nextByte;
  logic [7:0]       hdrByte;
  logic [7:0]       txBits;
  logic [7:0]       lastBit;
  logic             inRx;

  assign nextByte = bitCnt[7:3] + 5'd1;
  assign txBits   = {txBytesR, 3'b000};
  assign lastBit  = {txBytesR + {2'b00, rxBytesR}, 3'b000} - 8'd1;
  assign inRx     = bitCnt >= txBits;

  always_comb begin
    case (nextByte[1:0])
      2'd0:    hdrByte = hdr[31:24];
      2'd1:    hdrByte = hdr[23:16];
      2'd2:    hdrByte = hdr[15:8];
      default: hdrByte = hdr[7:0];
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0; divCnt <= '0; bitCnt <= '0; txSh <= '0; hdr <= '0;
      txBytesR <= '0; rxBytesR <= '0; rxSh <= '0; sclk <= 1'b0; csN <= 1'b1;
      frameDone <= 1'b0; byteTake <= 1'b0;
    end else begin
      frameDone <= 1'b0;
      byteTake  <= 1'b0;
      if (!active) begin
        if (req.go) begin
          active   <= 1'b1;
          csN      <= 1'b0;
          hdr      <= req.header;
          txBytesR <= req.txBytes;
          rxBytesR <= req.rxBytes;
          bitCnt   <= '0;
          divCnt   <= '0;
          sclk     <= 1'b0;
          rxSh     <= '0;
          txSh     <= req.header[31:24];
        end
      end else if (divCnt != DIV_W'(HALF_DIV - 1)) begin
        divCnt <= divCnt + 1'b1;
      end else begin
        divCnt <= '0;
        if (!sclk) begin
          sclk <= 1'b1;
          if (inRx) rxSh <= {rxSh[24:0], miso};
        end else begin
          sclk <= 1'b0;
          if (bitCnt == lastBit) begin
            active    <= 1'b0;
            csN       <= 1'b1;
            frameDone <= 1'b1;
          end else begin
            bitCnt <= bitCnt + 8'd1;
            if (bitCnt[2:0] == 3'd7) begin
              if (nextByte < 5'(HDR_BYTES)) begin
                txSh <= hdrByte;
              end else if (nextByte < txBytesR) begin
                txSh     <= dataIn;
                byteTake <= 1'b1;
              end else begin
                txSh <= 8'h00;
              end
            end else begin
              txSh <= {txSh[6:0], 1'b0};
            end
          end
        end
      end
    end
  end

  assign mosi      = active & txSh[7];
  assign frameBusy = active;
  assign rsp.pollByte = rxSh[7:0];
  assign rsp.doneF    = rxSh[8];
  assign rsp.busyF    = rxSh[12];
  assign rsp.failF    = rxSh[13];
  assign rsp.errF     = rxSh[25:23];

  // R2: clock idles low outside a frame
  a_r2_sclk_idle: assert property (@(posedge clk) disable iff (!rstN) csN |-> !sclk);
  // R2: data held steady while the clock is high
  a_r2_mosi_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && sclk && $past(sclk)) |-> $stable(mosi));
  // R7: stream bytes are only taken inside a frame
  a_r7_take_in_frame: assert property (@(posedge clk) disable iff (!rstN) byteTake |-> !csN);
endmodule

// File: rtl/cfg_seq_ctrl.sv
module cfg_seq_ctrl
  import cfg_seq_pkg::*;
#(
  parameter int LEN_W         = 16,
  parameter int WAIT_W        = 20,
  parameter int POLL_LIMIT    = 100000,
  parameter int REFRESH_LIMIT = 100000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [LEN_W-1:0]  imageLen,
  input  logic [WAIT_W-1:0] refreshWait,
  input  logic              frameBusy,
  input  logic              frameDone,
  input  rsp_t              rsp,
  output frameReq_t         req,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic              errInPage,
  output logic [LEN_W-5:0]  errPage
);
  localparam int PAGE_W = LEN_W - 4;
  localparam int POLL_W = (POLL_LIMIT > 1) ? $clog2(POLL_LIMIT) : 1;
  localparam int REF_W  = (REFRESH_LIMIT > 1) ? $clog2(REFRESH_LIMIT) : 1;

  seqState_t         state;
  seqStep_t          step;
  logic              issued;
  logic [POLL_W-1:0] pollCnt;
  logic [REF_W-1:0]  refCnt;
  logic [WAIT_W-1:0] waitCnt;
  logic [PAGE_W-1:0] pageIdx;
  logic [PAGE_W-1:0] numPages;
  logic              sending;
  logic              healthy;

  assign sending = (state != S_IDLE) && (state != S_WAIT);
  assign healthy = rsp.doneF && !rsp.busyF && (rsp.errF == 3'b000);

  always_comb begin
    req.header  = {OP_POLL, 24'h0};
    req.txBytes = 5'(HDR_BYTES);
    req.rxBytes = 3'd0;
    case (state)
      S_ENABLE:     req.header = {OP_ENABLE, ARG_ENABLE, 16'h0000};
      S_ERASE,
      S_CL_ERASE:   req.header = {OP_ERASE, ARG_ERASE, 16'h0000};
      S_POLL:       req.rxBytes = 3'd1;
      S_STAT: begin
        req.header  = {OP_STATUS, 24'h0};
        req.rxBytes = 3'd4;
      end
      S_INITA:      req.header = {OP_INITA, 24'h0};
      S_PAGE: begin
        req.header  = {OP_PAGE, 24'h000001};
        req.txBytes = 5'(HDR_BYTES + PAGE_BYTES);
      end
      S_PDONE:      req.header = {OP_PDONE, 24'h0};
      S_DISABLE:    req.header = {OP_DISABLE, 24'h0};
      S_REFRESH,
      S_CL_REFRESH: req.header = {OP_REFRESH, 24'h0};
      default:      req.header = {OP_POLL, 24'h0};
    endcase
    req.go = sending && !issued;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE; step <= K_EN; issued <= 1'b0;
      pollCnt <= '0; refCnt <= '0; waitCnt <= '0; pageIdx <= '0; numPages <= '0;
      busy <= 1'b0; done <= 1'b0; error <= 1'b0; errInPage <= 1'b0; errPage <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (start) begin
            done <= 1'b0; error <= 1'b0; errInPage <= 1'b0; errPage <= '0;
            if (imageLen[3:0] != 4'd0) begin
              error <= 1'b1;
            end else begin
              busy     <= 1'b1;
              numPages <= imageLen[LEN_W-1:4];
              pageIdx  <= '0;
              refCnt   <= '0;
              step     <= K_EN;
              state    <= S_ENABLE;
            end
          end
        end
        S_WAIT: begin
          if (waitCnt >= refreshWait) begin
            if (step == K_CL) begin
              state <= S_IDLE; busy <= 1'b0; error <= 1'b1;
            end else begin
              state <= S_STAT;
            end
          end else begin
            waitCnt <= waitCnt + 1'b1;
          end
        end
        default: begin
          if (!issued) begin
            issued <= 1'b1;
          end else if (frameDone) begin
            issued <= 1'b0;
            case (state)
              S_ENABLE, S_ERASE, S_CL_ERASE, S_PAGE, S_PDONE: begin
                pollCnt <= '0;
                state   <= S_POLL;
              end
              S_INITA: begin
                if (numPages == '0) begin
                  state <= S_PDONE; step <= K_PD;
                end else begin
                  state <= S_PAGE; step <= K_PG;
                end
              end
              S_DISABLE: begin
                state <= S_REFRESH; step <= K_RF;
              end
              S_REFRESH, S_CL_REFRESH: begin
                waitCnt <= '0;
                state   <= S_WAIT;
              end
              S_POLL: begin
                if (rsp.pollByte != 8'h00) begin
                  if (pollCnt == POLL_W'(POLL_LIMIT - 1)) begin
                    if (step == K_CL) begin
                      state <= S_CL_REFRESH;
                    end else begin
                      if (step == K_PG) begin
                        errInPage <= 1'b1;
                        errPage   <= pageIdx;
                      end
                      state <= S_CL_ERASE; step <= K_CL;
                    end
                  end else begin
                    pollCnt <= pollCnt + 1'b1;
                  end
                end else if (step == K_PG) begin
                  if (pageIdx == numPages - 1'b1) begin
                    state <= S_PDONE; step <= K_PD;
                  end else begin
                    pageIdx <= pageIdx + 1'b1;
                    state   <= S_PAGE;
                  end
                end else begin
                  state <= S_STAT;
                end
              end
              S_STAT: begin
                case (step)
                  K_EN: begin
                    if (rsp.failF) begin
                      state <= S_CL_ERASE; step <= K_CL;
                    end else begin
                      state <= S_ERASE; step <= K_ER;
                    end
                  end
                  K_ER: begin
                    if (rsp.failF) begin
                      state <= S_CL_ERASE; step <= K_CL;
                    end else begin
                      state <= S_INITA;
                    end
                  end
                  K_PD: begin
                    if (rsp.doneF) begin
                      state <= S_DISABLE;
                    end else begin
                      state <= S_CL_ERASE; step <= K_CL;
                    end
                  end
                  K_RF: begin
                    if (healthy) begin
                      state <= S_IDLE; busy <= 1'b0; done <= 1'b1;
                    end else if (refCnt == REF_W'(REFRESH_LIMIT - 1)) begin
                      state <= S_CL_ERASE; step <= K_CL;
                    end else begin
                      refCnt <= refCnt + 1'b1;
                      state  <= S_REFRESH;
                    end
                  end
                  default: state <= S_CL_REFRESH;
                endcase
              end
              default: state <= S_IDLE;
            endcase
          end
        end
      endcase
    end
  end

  // R12: outcome flags are exclusive and cleared while running
  a_r12_flags_excl: assert property (@(posedge clk) disable iff (!rstN) !(done && error));
  a_r12_busy_clear: assert property (@(posedge clk) disable iff (!rstN) busy |-> (!done && !error));
  // R2: a new frame is only requested while the shifter is idle
  a_r2_go_idle: assert property (@(posedge clk) disable iff (!rstN) req.go |-> !frameBusy);
  // R3: malformed length fails at once without starting
  a_r3_malformed: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && (imageLen[3:0] != 4'd0)) |=> (error && !busy));
  // R7: page frames stay inside the image
  a_r7_page_range: assert property (@(posedge clk) disable iff (!rstN)
    (req.go && state == S_PAGE) |-> (pageIdx < numPages));
  // R5 / R9: retry counters stay under their limits
  a_r5_poll_limit: assert property (@(posedge clk) disable iff (!rstN) pollCnt <= POLL_W'(POLL_LIMIT - 1));
  a_r9_refresh_limit: assert property (@(posedge clk) disable iff (!rstN) refCnt <= REF_W'(REFRESH_LIMIT - 1));
endmodule

// File: rtl/cfg_page_seq.sv
module cfg_page_seq
  import cfg_seq_pkg::*;
#(
  parameter int HALF_DIV      = 2,
  parameter int LEN_W         = 16,
  parameter int WAIT_W        = 20,
  parameter int POLL_LIMIT    = 100000,
  parameter int REFRESH_LIMIT = 100000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [LEN_W-1:0]  imageLen,
  input  logic [WAIT_W-1:0] refreshWait,
  input  logic [7:0]        dataIn,
  output logic              byteTake,
  output logic              sclk,
  output logic              mosi,
  output logic              csN,
  input  logic              miso,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic              errInPage,
  output logic [LEN_W-5:0]  errPage
);
  frameReq_t req;
  rsp_t      rsp;
  logic      frameBusy;
  logic      frameDone;

  cfg_seq_ctrl #(
    .LEN_W(LEN_W), .WAIT_W(WAIT_W),
    .POLL_LIMIT(POLL_LIMIT), .REFRESH_LIMIT(REFRESH_LIMIT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .imageLen(imageLen),
    .refreshWait(refreshWait), .frameBusy(frameBusy), .frameDone(frameDone),
    .rsp(rsp), .req(req), .busy(busy), .done(done), .error(error),
    .errInPage(errInPage), .errPage(errPage)
  );

  cfg_seq_spi #(.HALF_DIV(HALF_DIV)) u_spi (
    .clk(clk), .rstN(rstN), .req(req), .frameBusy(frameBusy),
    .frameDone(frameDone), .rsp(rsp), .dataIn(dataIn), .byteTake(byteTake),
    .sclk(sclk), .mosi(mosi), .csN(csN), .miso(miso)
  );
endmodule

// File: tb/cfg_page_seq_tb.sv
`timescale 1ns/1ps
module cfg_page_seq_tb;
  localparam int HALF_DIV = 1;
  localparam int LEN_W = 16;
  localparam int WAIT_W = 20;
  localparam int POLL_LIMIT = 6;
  localparam int REFRESH_LIMIT = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [LEN_W-1:0] imageLen = '0;
  logic [WAIT_W-1:0] refreshWait = '0;
  logic [7:0] dataIn;
  logic byteTake, sclk, mosi, csN, busy, done, error, errInPage;
  logic miso = 1'b0;
  logic [LEN_W-5:0] errPage;

  always #2.5 clk = ~clk;

  cfg_page_seq #(.HALF_DIV(HALF_DIV), .LEN_W(LEN_W), .WAIT_W(WAIT_W),
    .POLL_LIMIT(POLL_LIMIT), .REFRESH_LIMIT(REFRESH_LIMIT)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .imageLen(imageLen),
    .refreshWait(refreshWait), .dataIn(dataIn), .byteTake(byteTake),
    .sclk(sclk), .mosi(mosi), .csN(csN), .miso(miso), .busy(busy),
    .done(done), .error(error), .errInPage(errInPage), .errPage(errPage));

  int checks = 0;
  int fails = 0;

  // image stream
  logic [7:0] img [0:255];
  int imgIdx = 0;
  assign dataIn = img[imgIdx];

  // target model configuration and state
  int busyPerCmd = 0, stuckPage = -1, refreshBad = 0;
  bit failEnable = 0, pdDoneOk = 1;
  int busyLeft = 0, pageNo = 0;
  bit stuck = 0;
  logic [31:0] statusReg = '0;
  logic [31:0] resp = '0;
  logic [7:0] fb [0:31];
  logic [7:0] cur = '0;
  int bitCnt = 0, nb = 0;
  logic prevS = 1'b0, prevC = 1'b1;
  int cycle = 0, lastRise = -1, lastRefEnd = 0, lastGap = -1;
  bit refPending = 0;
  int pageErr = 0, frameErr = 0, sclkErr = 0, cycErr = 0;
  logic [15:0] opLog [$];
  logic [15:0] expQ [$];

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  function automatic logic [31:0] respond(input logic [7:0] op);
    logic [7:0] b;
    if (op == 8'hF0) begin
      b = (stuck || busyLeft > 0) ? 8'h01 : 8'h00;
      if (!stuck && busyLeft > 0) busyLeft--;
      return {b, 24'h0};
    end else if (op == 8'h3C) return statusReg;
    return 32'h0;
  endfunction

  function automatic int expLen(input logic [7:0] op);
    if (op == 8'hF0) return 5;
    if (op == 8'h3C) return 8;
    if (op == 8'h70) return 20;
    return 4;
  endfunction

  task automatic endFrame();
    opLog.push_back({fb[0], fb[1]});
    if (nb != expLen(fb[0]) || (bitCnt % 8) != 0) frameErr++;
    if (fb[0] != 8'h70 && nb >= 4 && (fb[2] != 8'h00 || fb[3] != 8'h00)) frameErr++;
    case (fb[0])
      8'hC6: begin statusReg = failEnable ? 32'h2000 : 32'h0; busyLeft = busyPerCmd; end
      8'h0E: begin stuck = 0; statusReg = 32'h0; busyLeft = busyPerCmd; end
      8'h70: begin
        if (fb[1] != 8'h00 || fb[2] != 8'h00 || fb[3] != 8'h01) frameErr++;
        for (int i = 0; i < 16; i++)
          if (fb[4+i] != img[pageNo*16+i]) pageErr++;
        if (pageNo == stuckPage) stuck = 1;
        pageNo++;
        busyLeft = busyPerCmd;
      end
      8'h5E: begin statusReg = pdDoneOk ? 32'h100 : 32'h0; busyLeft = busyPerCmd; end
      8'h79: begin
        if (refreshBad > 0) begin
          statusReg = (refreshBad % 2) ? 32'h1100 : 32'h0100_0100;
          refreshBad--;
        end else statusReg = 32'h100;
        lastRefEnd = cycle;
        refPending = 1;
      end
      default: ;
    endcase
  endtask

  always @(negedge clk) begin
    cycle++;
    if (byteTake) imgIdx++;
    if (prevC && !csN) begin
      bitCnt = 0; nb = 0; lastRise = -1;
      if (refPending) begin lastGap = cycle - lastRefEnd; refPending = 0; end
    end
    if (!csN && sclk && !prevS) begin
      if (lastRise >= 0 && cycle - lastRise != 2*HALF_DIV) sclkErr++;
      lastRise = cycle;
      cur = {cur[6:0], mosi};
      bitCnt++;
      if (bitCnt % 8 == 0) begin
        if (nb < 32) fb[nb] = cur;
        nb++;
      end
      if (bitCnt == 32) resp = respond(fb[0]);
    end
    miso = (!csN && bitCnt >= 32 && bitCnt < 64) ? resp[63-bitCnt] : 1'b0;
    if (!prevC && csN) endFrame();
    prevS = sclk;
    prevC = csN;
    if (rstN) begin
      if (!busy && (csN !== 1'b1 || sclk !== 1'b0)) cycErr++;
      if (done && error) cycErr++;
    end
  end

  task automatic eAdd(input logic [15:0] v, input int n);
    for (int i = 0; i < n; i++) expQ.push_back(v);
  endtask

  task automatic eHead(input int bpc);
    eAdd(16'hC608, 1); eAdd(16'hF000, bpc+1); eAdd(16'h3C00, 1);
    eAdd(16'h0E04, 1); eAdd(16'hF000, bpc+1); eAdd(16'h3C00, 1);
    eAdd(16'h4600, 1);
  endtask

  task automatic eClean(input int bpc);
    eAdd(16'h0E04, 1); eAdd(16'hF000, bpc+1); eAdd(16'h3C00, 1); eAdd(16'h7900, 1);
  endtask

  task automatic cmpSeq(input string rq);
    int bad = -1;
    if (opLog.size() != expQ.size()) begin
      chk(0, rq, "command count", opLog.size(), expQ.size());
      return;
    end
    for (int i = 0; i < expQ.size(); i++)
      if (bad < 0 && opLog[i] != expQ[i]) bad = i;
    if (bad < 0) chk(1, rq, "command sequence", 0, 0);
    else chk(0, rq, "command at index", opLog[bad], expQ[bad]);
  endtask

  task automatic setup(input int bpc, input int sp, input bit fe, input bit pd, input int rb);
    busyPerCmd = bpc; stuckPage = sp; failEnable = fe; pdDoneOk = pd; refreshBad = rb;
    busyLeft = 0; stuck = 0; pageNo = 0; statusReg = '0; imgIdx = 0;
    pageErr = 0; frameErr = 0; lastGap = -1; refPending = 0;
    opLog.delete(); expQ.delete();
    for (int i = 0; i < 256; i++) img[i] = 8'(i * 37 + bpc * 11 + 5);
  endtask

  task automatic run(input int len, input int waitC, input bit poke);
    @(negedge clk);
    imageLen = LEN_W'(len); refreshWait = WAIT_W'(waitC); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (60) @(negedge clk);
      imageLen = LEN_W'(40); start = 1'b1;
      @(negedge clk);
      start = 1'b0; imageLen = LEN_W'(len);
    end
    while (!(done || error)) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) img[i] = 8'h00;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(busy == 0, "R1", "busy", busy, 0);
    chk(done == 0 && error == 0, "R1", "done|error", {done, error}, 0);
    chk(csN == 1 && sclk == 0, "R1", "csN,sclk", {csN, sclk}, 2);
    chk(errInPage == 0, "R1", "errInPage", errInPage, 0);
    rstN = 1'b1;

    // A: three pages, busy replies, ignored second start (R4 R5 R6 R7 R8 R9 R12)
    setup(2, -1, 0, 1, 0);
    run(48, 5, 1);
    chk(done == 1 && error == 0, "R12", "done after good run", {done, error}, 2);
    eHead(2);
    for (int p = 0; p < 3; p++) begin eAdd(16'h7000, 1); eAdd(16'hF000, 3); end
    eAdd(16'h5E00, 1); eAdd(16'hF000, 3); eAdd(16'h3C00, 1);
    eAdd(16'h2600, 1); eAdd(16'h7900, 1); eAdd(16'h3C00, 1);
    cmpSeq("R4 R5 R6 R8");
    chk(pageErr == 0, "R7", "page data mismatches", pageErr, 0);
    chk(imgIdx == 48, "R7", "bytes taken", imgIdx, 48);
    chk(frameErr == 0, "R2", "frame format errors", frameErr, 0);
    chk(lastGap >= 6 && lastGap <= 9, "R9", "refresh gap", lastGap, 8);

    // B: unhealthy refresh replies retried (R9)
    setup(0, -1, 0, 1, 3);
    run(32, 12, 0);
    chk(done == 1 && error == 0, "R9", "done after retries", {done, error}, 2);
    eHead(0);
    for (int p = 0; p < 2; p++) begin eAdd(16'h7000, 1); eAdd(16'hF000, 1); end
    eAdd(16'h5E00, 1); eAdd(16'hF000, 1); eAdd(16'h3C00, 1); eAdd(16'h2600, 1);
    for (int k = 0; k < 4; k++) begin eAdd(16'h7900, 1); eAdd(16'h3C00, 1); end
    cmpSeq("R9");
    chk(lastGap >= 13 && lastGap <= 16, "R9", "refresh gap long wait", lastGap, 15);

    // C: malformed length (R3)
    setup(0, -1, 0, 1, 0);
    run(40, 2, 0);
    chk(error == 1 && done == 0, "R3", "error on malformed", {done, error}, 1);
    chk(opLog.size() == 0, "R3", "frames sent", opLog.size(), 0);
    chk(busy == 0 && imgIdx == 0, "R3", "busy or bytes", busy + imgIdx, 0);

    // D: page 1 never clears busy (R5 R10 R11)
    setup(1, 1, 0, 1, 0);
    run(48, 2, 0);
    chk(error == 1 && done == 0, "R10", "error after page timeout", {done, error}, 1);
    chk(errInPage == 1, "R11", "errInPage", errInPage, 1);
    chk(errPage == 1, "R11", "errPage", errPage, 1);
    eHead(1);
    eAdd(16'h7000, 1); eAdd(16'hF000, 2); eAdd(16'h7000, 1); eAdd(16'hF000, POLL_LIMIT);
    eClean(1);
    cmpSeq("R5 R10");

    // E: FAIL bit after enable (R4 R10 R11)
    setup(0, -1, 1, 1, 0);
    run(16, 2, 0);
    chk(error == 1 && errInPage == 0, "R11", "error without page flag", {error, errInPage}, 2);
    eAdd(16'hC608, 1); eAdd(16'hF000, 1); eAdd(16'h3C00, 1); eClean(0);
    cmpSeq("R4 R10");

    // F: DONE missing after program-done (R8)
    setup(0, -1, 0, 0, 0);
    run(16, 2, 0);
    chk(error == 1 && done == 0, "R8", "error without DONE", {done, error}, 1);
    eHead(0); eAdd(16'h7000, 1); eAdd(16'hF000, 1);
    eAdd(16'h5E00, 1); eAdd(16'hF000, 1); eAdd(16'h3C00, 1); eClean(0);
    cmpSeq("R8");

    // G: refresh never healthy (R9 R10)
    setup(0, -1, 0, 1, 50);
    run(16, 1, 0);
    chk(error == 1, "R9", "error after refresh limit", error, 1);
    eHead(0); eAdd(16'h7000, 1); eAdd(16'hF000, 1);
    eAdd(16'h5E00, 1); eAdd(16'hF000, 1); eAdd(16'h3C00, 1); eAdd(16'h2600, 1);
    for (int k = 0; k < REFRESH_LIMIT; k++) begin eAdd(16'h7900, 1); eAdd(16'h3C00, 1); end
    eClean(0);
    cmpSeq("R9 R10");

    // H: zero-length image (R6 R7)
    setup(0, -1, 0, 1, 0);
    run(0, 0, 0);
    chk(done == 1, "R7", "done with no pages", done, 1);
    eHead(0); eAdd(16'h5E00, 1); eAdd(16'hF000, 1); eAdd(16'h3C00, 1);
    eAdd(16'h2600, 1); eAdd(16'h7900, 1); eAdd(16'h3C00, 1);
    cmpSeq("R6 R7");

    chk(sclkErr == 0, "R2", "sclk period errors", sclkErr, 0);
    chk(cycErr == 0, "R12", "per-cycle idle/flag errors", cycErr, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule